// File: doc/BRIEF.md
# Shadow Segment Access Router

This block sits beside a host bridge and decides, for every CPU memory access, whether the access is served by local DRAM or sent down the ROM/PCI path. Its work is confined to the upper-memory window from 0xC0000 to 0xFFFFF. That window is split into twelve 16 KB segments and one 64 KB segment. Each segment carries its own read steering and its own write steering, so a read and a write to the same address may land on different targets. Firmware uses this to copy ROM contents into DRAM and then run from the copy.

Software sets the steering through seven byte-wide attribute registers in configuration space. Each register holds two 4-bit attribute fields. Routing is decided combinationally from the stored attributes, so an attribute write takes effect on the access in the following clock cycle.

For reads, the block also returns the data of the target it selected.

Top module: `shadow_route`

## Requirements
- R1: After reset, all seven attribute registers (offsets 0x59 to 0x5F) read back 0x00. Every read and every write inside 0xC0000 to 0xFFFFF is then routed to the ROM/PCI path.
- R2: Attribute field i (0 to 13) is held in the register at offset 0x59 + i/2. An even i occupies bits [3:0] and an odd i occupies bits [7:4]. A written byte reads back unchanged, including bits 2 and 3 of each field.
- R3: Bits 2 and 3 of a field are stored but have no effect on routing.
- R4: A read in a segment goes to DRAM exactly when bit 0 (read-enable) of that segment's field is 1. Otherwise it goes to the ROM/PCI path.
- R5: A write in a segment goes to DRAM exactly when bit 1 (write-enable) of that segment's field is 1. Otherwise it goes to the ROM/PCI path and DRAM does not capture it.
- R6: Field 1 governs 0xF0000 to 0xFFFFF. Field 2+k (k = 0 to 11) governs the 16 KB segment starting at 0xC0000 + k*0x4000.
- R7: Accesses outside 0xC0000 to 0xFFFFF, including those at or above 1 MB, always go to DRAM, whatever the attributes hold.
- R8: Field 0 is storage only and changes the route of no address.
- R9: A configuration write to an offset outside 0x59 to 0x5F changes no attribute. A configuration read of such an offset returns 0x00.
- R10: An attribute write seen at a clock edge changes the route from the next cycle on. It does not change the route in the cycle the write is presented.
- R11: While an access is valid, exactly one of `route_dram` and `route_rom` is 1. With no valid access, both are 0.
- R12: For a valid read, `acc_rdata` equals `dram_rdata` when routed to DRAM and `rom_rdata` when routed to ROM/PCI. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr |
| acc_valid | input | 1 | A memory access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Physical byte address |
| dram_rdata | input | 8 | Read data from DRAM |
| rom_rdata | input | 8 | Read data from the ROM/PCI path |
| route_dram | output | 1 | Access is steered to DRAM |
| route_rom | output | 1 | Access is steered to the ROM/PCI path |
| acc_rdata | output | 8 | Read data from the selected target |

## Verification
The bench sets one field at a time, each with read-enable only and then with write-enable only. It probes the first and last byte of every segment together with the bytes just outside it, so a segment boundary that is off by one, or a field that is swapped with its neighbour, shows up as a wrong target. Attribute values that differ only in bits 2 and 3 separate stored-only bits from routing bits. Reads and writes to the same address under asymmetric enables show that the two directions are steered independently. A small DRAM model is filled with enables set and read again after the field is cleared, which shows that the written data stops being returned. An attribute write presented in the same cycle as an access separates the old route from the new one.

// File: rtl/shr_pkg.sv
package shr_pkg;

    localparam int ATTR_REGS   = 7;
    localparam int ATTR_FIELDS = 2 * ATTR_REGS;
    localparam int FIELD_W     = 4;
    localparam int IDX_W       = $clog2(ATTR_FIELDS);
    localparam logic [7:0] ATTR_BASE = 8'h59;

    // bit positions inside one attribute nibble
    localparam int RD_BIT = 0;
    localparam int WR_BIT = 1;

    // field that owns the 64 KB top segment, and the first 16 KB one
    localparam logic [IDX_W-1:0] TOP_FIELD   = IDX_W'(1);
    localparam logic [IDX_W-1:0] FIRST_SMALL = IDX_W'(2);

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } seg_sel_t;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_DRAM = 2'd1,
        TGT_ROM  = 2'd2
    } target_e;

    // offset of a configuration byte relative to the attribute block
    function automatic logic attr_in_range(input logic [7:0] off);
        return (off >= ATTR_BASE) && (off < ATTR_BASE + 8'(ATTR_REGS));
    endfunction

    // decode address bits [19:14] (upper bits already known zero)
    function automatic seg_sel_t seg_of(input logic [5:0] a19_14);
        seg_sel_t s;
        s.hit = (a19_14[5:4] == 2'b11);
        if (a19_14[3:2] == 2'b11) begin
            s.idx = TOP_FIELD;
        end else begin
            s.idx = FIRST_SMALL + IDX_W'(a19_14[3:0]);
        end
        return s;
    endfunction

endpackage

// File: rtl/shr_attr_regs.sv
module shr_attr_regs
    import shr_pkg::*;
#(
    parameter int         NREGS = ATTR_REGS,
    parameter logic [7:0] BASE  = ATTR_BASE
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr,
    input  logic [7:0]            addr,
    input  logic [7:0]            wdata,
    output logic [7:0]            rdata,
    output logic [NREGS-1:0][7:0] regs_q
);

    localparam int OFF_W = (NREGS > 1) ? $clog2(NREGS) : 1;

    logic [7:0]       rel;
    logic             in_rng;
    logic [OFF_W-1:0] rsel;

    assign rel    = addr - BASE;
    assign in_rng = (addr >= BASE) && (rel < 8'(NREGS));
    assign rsel   = rel[OFF_W-1:0];

    for (genvar k = 0; k < NREGS; k++) begin : g_reg
        logic hit;
        assign hit = wr && in_rng && (rel == 8'(k));
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[k] <= 8'h00;
            end else if (hit) begin
                regs_q[k] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (in_rng) begin
            rdata = regs_q[rsel];
        end
    end

endmodule

// File: rtl/shr_seg_decode.sv
module shr_seg_decode
    import shr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:14] addr_hi,
    output seg_sel_t           sel
);

    logic below_1m;
    seg_sel_t raw;

    if (ADDR_W > 20) begin : g_wide
        assign below_1m = (addr_hi[ADDR_W-1:20] == '0);
    end else begin : g_narrow
        assign below_1m = 1'b1;
    end

    assign raw = seg_of(addr_hi[19:14]);

    always_comb begin
        sel     = raw;
        sel.hit = raw.hit && below_1m;
    end

endmodule

// File: rtl/shr_route_sel.sv
module shr_route_sel
    import shr_pkg::*;
#(
    parameter int NFIELDS = ATTR_FIELDS
) (
    input  logic [NFIELDS-1:0] rd_en,
    input  logic [NFIELDS-1:0] wr_en,
    input  seg_sel_t           sel,
    input  logic               valid,
    input  logic               write,
    input  logic [7:0]         dram_rdata,
    input  logic [7:0]         rom_rdata,
    output target_e            tgt,
    output logic [7:0]         rdata
);

    logic en_bit;

    always_comb begin
        en_bit = write ? wr_en[sel.idx] : rd_en[sel.idx];
        if (!valid) begin
            tgt = TGT_NONE;
        end else if (!sel.hit || en_bit) begin
            tgt = TGT_DRAM;
        end else begin
            tgt = TGT_ROM;
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (valid && !write) begin
            rdata = (tgt == TGT_DRAM) ? dram_rdata : rom_rdata;
        end
    end

endmodule

// File: rtl/shadow_route.sv
module shadow_route
    import shr_pkg::*;
#(
    parameter int         ADDR_W   = 32,
    parameter logic [7:0] REG_BASE = ATTR_BASE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [7:0]        dram_rdata,
    input  logic [7:0]        rom_rdata,
    output logic              route_dram,
    output logic              route_rom,
    output logic [7:0]        acc_rdata
);

    logic [ATTR_REGS-1:0][7:0] attr_q;
    logic [ATTR_FIELDS-1:0]    rd_en;
    logic [ATTR_FIELDS-1:0]    wr_en;
    seg_sel_t                  sel;
    target_e                   tgt;

    shr_attr_regs #(.NREGS(ATTR_REGS), .BASE(REG_BASE)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (cfg_wr),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .regs_q (attr_q)
    );

    // unpack nibbles: even field low half, odd field high half
    for (genvar f = 0; f < ATTR_FIELDS; f++) begin : g_field
        logic [FIELD_W-1:0] nib;
        assign nib      = attr_q[f/2][(f%2)*FIELD_W +: FIELD_W];
        assign rd_en[f] = nib[RD_BIT];
        assign wr_en[f] = nib[WR_BIT];
    end

    shr_seg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_hi (acc_addr[ADDR_W-1:14]),
        .sel     (sel)
    );

    shr_route_sel #(.NFIELDS(ATTR_FIELDS)) u_sel (
        .rd_en      (rd_en),
        .wr_en      (wr_en),
        .sel        (sel),
        .valid      (acc_valid),
        .write      (acc_write),
        .dram_rdata (dram_rdata),
        .rom_rdata  (rom_rdata),
        .tgt        (tgt),
        .rdata      (acc_rdata)
    );

    assign route_dram = (tgt == TGT_DRAM);
    assign route_rom  = (tgt == TGT_ROM);

endmodule

// File: rtl/shr_checks.sv
module shr_checks #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_wr,
    input logic [7:0]        cfg_addr,
    input logic [7:0]        cfg_rdata,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [7:0]        dram_rdata,
    input logic [7:0]        rom_rdata,
    input logic              route_dram,
    input logic              route_rom,
    input logic [7:0]        acc_rdata,
    input logic [6:0][7:0]   attr_q
);

    logic in_win;
    logic cfg_out;
    assign in_win  = (64'(acc_addr) >= 64'h000C_0000) && (64'(acc_addr) < 64'h0010_0000);
    assign cfg_out = (cfg_addr < 8'h59) || (cfg_addr > 8'h5F);

    // R1: straight after reset nothing in the window reaches DRAM
    p_reset_rom_r1: assert property (@(posedge clk)
        rst |=> !(acc_valid && in_win && route_dram));

    // R7: outside the window always DRAM
    p_outside_dram_r7: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !in_win) |-> route_dram);

    // R9: stray offsets leave attributes untouched
    p_stray_write_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_out) |=> $stable(attr_q));

    // R9: stray offsets read as zero
    p_stray_read_r9: assert property (@(posedge clk) disable iff (rst)
        cfg_out |-> (cfg_rdata == 8'h00));

    // R11: one target while valid, none while idle
    p_one_target_r11: assert property (@(posedge clk) disable iff (rst)
        acc_valid |-> ($countones({route_dram, route_rom}) == 1));
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> !(route_dram || route_rom));

    // R12: returned data follows the chosen target
    p_rdata_follow_r12: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write) |->
            (acc_rdata == (route_dram ? dram_rdata : rom_rdata)));

endmodule

bind shadow_route shr_checks #(.ADDR_W(ADDR_W)) u_shr_checks (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr     (cfg_wr),
    .cfg_addr   (cfg_addr),
    .cfg_rdata  (cfg_rdata),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_addr   (acc_addr),
    .dram_rdata (dram_rdata),
    .rom_rdata  (rom_rdata),
    .route_dram (route_dram),
    .route_rom  (route_rom),
    .acc_rdata  (acc_rdata),
    .attr_q     (attr_q)
);

// File: tb/shadow_route_bench.sv
`timescale 1ns/1ps
module shadow_route_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [31:0] acc_addr = 32'h0;
    logic [7:0]  acc_wdata = 8'h00;
    logic [7:0]  dram_rdata;
    logic [7:0]  rom_rdata;
    logic        route_dram;
    logic        route_rom;
    logic [7:0]  acc_rdata;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] shadow [0:6];

    always #2 clk = ~clk;   // 250 MHz

    // DRAM model: one byte per 16 KB block below 1 MB; ROM returns 0xFF
    logic [7:0] dram_mem [0:63];
    assign dram_rdata = dram_mem[acc_addr[19:14]];
    assign rom_rdata  = 8'hFF;
    always @(posedge clk) begin
        if (acc_valid && acc_write && route_dram) begin
            dram_mem[acc_addr[19:14]] <= acc_wdata;
        end
    end

    shadow_route u_shadow_route (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .dram_rdata(dram_rdata), .rom_rdata(rom_rdata),
        .route_dram(route_dram), .route_rom(route_rom), .acc_rdata(acc_rdata)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // expected owner field of an address, -1 when outside the window
    function automatic int owner(input logic [31:0] a);
        if (a >= 32'hF0000 && a <= 32'hFFFFF) return 1;
        if (a >= 32'hC0000 && a <  32'hF0000) return 2 + int'((a - 32'hC0000) / 32'h4000);
        return -1;
    endfunction

    function automatic bit exp_dram(input logic [31:0] a, input bit w);
        int f;
        logic [3:0] nib;
        f = owner(a);
        if (f < 0) return 1'b1;
        nib = (f % 2 == 1) ? shadow[f/2][7:4] : shadow[f/2][3:0];
        return w ? nib[1] : nib[0];
    endfunction

    task automatic cfg_write(input logic [7:0] off, input logic [7:0] d);
        cfg_wr = 1'b1; cfg_addr = off; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (off >= 8'h59 && off <= 8'h5F) shadow[off - 8'h59] = d;
    endtask

    task automatic set_field(input int f, input logic [3:0] v);
        logic [7:0] r;
        r = shadow[f/2];
        if (f % 2 == 1) r[7:4] = v; else r[3:0] = v;
        cfg_write(8'h59 + 8'(f/2), r);
    endtask

    task automatic cfg_read(input logic [7:0] off, output logic [7:0] d);
        cfg_addr = off;
        #0.5;
        d = cfg_rdata;
    endtask

    // present an access for one cycle, sampled mid-cycle
    task automatic probe(input logic [31:0] a, input bit w, input string req);
        bit e;
        acc_valid = 1'b1; acc_addr = a; acc_write = w;
        #0.5;
        e = exp_dram(a, w);
        check(route_dram == e && route_rom == !e, req, {route_dram, route_rom}, {e, !e});
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic clear_all();
        for (int k = 0; k < 7; k++) cfg_write(8'h59 + 8'(k), 8'h00);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int k = 0; k < 7; k++) begin
            cfg_read(8'h59 + 8'(k), d);
            check(d == 8'h00, "R1 reset value", d, 0);
        end
        probe(32'hC0000, 1'b0, "R1 read to ROM");
        probe(32'hFFFFF, 1'b1, "R1 write to ROM");
        probe(32'hE7FFF, 1'b0, "R1 read to ROM");
    endtask

    task automatic t_readback();
        logic [7:0] d;
        for (int k = 0; k < 7; k++) cfg_write(8'h59 + 8'(k), 8'(8'hA5 ^ (k * 8'h13)));
        for (int k = 0; k < 7; k++) begin
            cfg_read(8'h59 + 8'(k), d);
            check(d == 8'(8'hA5 ^ (k * 8'h13)), "R2 readback", d, 8'(8'hA5 ^ (k * 8'h13)));
        end
        clear_all();
    endtask

    // every field alone, read-enable then write-enable, at segment edges
    task automatic t_map();
        logic [31:0] lo, hi;
        for (int f = 1; f < 14; f++) begin
            if (f == 1) begin lo = 32'hF0000; hi = 32'hFFFFF; end
            else begin lo = 32'hC0000 + 32'((f - 2) * 32'h4000); hi = lo + 32'h3FFF; end
            set_field(f, 4'b0001);
            probe(lo, 1'b0, "R6 R4 segment start read");
            probe(hi, 1'b0, "R6 R4 segment end read");
            probe(lo, 1'b1, "R5 write blocked");
            probe(lo - 1, 1'b0, "R6 below segment");
            probe(hi + 1, 1'b0, "R6 R7 above segment");
            set_field(f, 4'b0010);
            probe(hi, 1'b1, "R6 R5 segment write");
            probe(hi, 1'b0, "R4 read blocked");
            set_field(f, 4'b0000);
        end
    endtask

    task automatic t_stored_bits();
        set_field(4, 4'b1100);
        probe(32'hC8000, 1'b0, "R3 bits 2-3 no read route");
        probe(32'hC8000, 1'b1, "R3 bits 2-3 no write route");
        set_field(4, 4'b1101);
        probe(32'hC8000, 1'b0, "R3 with read enable");
        probe(32'hC8000, 1'b1, "R3 with read enable write");
        set_field(4, 4'b0000);
    endtask

    task automatic t_field0();
        cfg_write(8'h59, 8'h0F);
        for (int k = 0; k < 16; k++) probe(32'hC0000 + 32'(k * 32'h4000), k[0], "R8 field 0 inert");
        cfg_write(8'h59, 8'h00);
    endtask

    task automatic t_outside();
        probe(32'h00000, 1'b0, "R7 low memory read");
        probe(32'hBFFFF, 1'b1, "R7 below window write");
        probe(32'h100000, 1'b0, "R7 at 1 MB read");
        probe(32'hFFFF0000, 1'b0, "R7 high address read");
        probe(32'h000F0000 | 32'h1000_0000, 1'b1, "R7 alias above 1 MB");
    endtask

    task automatic t_stray();
        logic [7:0] d;
        cfg_write(8'h58, 8'hFF);
        cfg_write(8'h60, 8'hFF);
        cfg_write(8'h00, 8'hFF);
        for (int k = 0; k < 7; k++) begin
            cfg_read(8'h59 + 8'(k), d);
            check(d == 8'h00, "R9 stray write ignored", d, 0);
        end
        probe(32'hF0000, 1'b0, "R9 route unchanged");
        cfg_read(8'h58, d); check(d == 8'h00, "R9 stray read zero", d, 0);
        cfg_read(8'h60, d); check(d == 8'h00, "R9 stray read zero", d, 0);
    endtask

    task automatic t_next_cycle();
        // write and access in the same cycle: old route
        cfg_wr = 1'b1; cfg_addr = 8'h5C; cfg_wdata = 8'h11;
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 32'hD4000;
        #0.5;
        check(route_rom == 1'b1, "R10 same cycle keeps old route", route_rom, 1);
        @(negedge clk);
        cfg_wr = 1'b0; shadow[3] = 8'h11;
        #0.5;
        check(route_dram == 1'b1, "R10 next cycle new route", route_dram, 1);
        @(negedge clk);
        acc_valid = 1'b0;
        #0.5;
        check(!route_dram && !route_rom, "R11 idle no target", {route_dram, route_rom}, 0);
        cfg_write(8'h5C, 8'h00);
    endtask

    task automatic t_data();
        // segment 0xCC000 is field 5
        set_field(5, 4'b0011);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 32'hCC010; acc_wdata = 8'h42;
        @(negedge clk);
        acc_write = 1'b0; #0.5;
        check(acc_rdata == 8'h42, "R12 DRAM data back", acc_rdata, 8'h42);
        @(negedge clk); acc_valid = 1'b0;
        set_field(5, 4'b0010);
        acc_valid = 1'b1; acc_write = 1'b1; acc_wdata = 8'h82;
        @(negedge clk);
        acc_write = 1'b0; #0.5;
        check(acc_rdata == 8'hFF, "R4 R12 read from ROM", acc_rdata, 8'hFF);
        @(negedge clk); acc_valid = 1'b0;
        set_field(5, 4'b0001);
        acc_valid = 1'b1; #0.5;
        check(acc_rdata == 8'h82, "R5 write reached DRAM", acc_rdata, 8'h82);
        @(negedge clk); acc_valid = 1'b0;
        set_field(5, 4'b0001);
        acc_valid = 1'b1; acc_write = 1'b1; acc_wdata = 8'h55;
        @(negedge clk);
        acc_write = 1'b0; #0.5;
        check(acc_rdata == 8'h82, "R5 write not captured", acc_rdata, 8'h82);
        @(negedge clk); acc_valid = 1'b0;
        set_field(5, 4'b0000);
        acc_valid = 1'b1; #0.5;
        check(acc_rdata != 8'h82, "R4 cleared stops data", acc_rdata, 8'hFF);
        @(negedge clk); acc_valid = 1'b0;
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int k = 0; k < 7; k++) shadow[k] = 8'h00;
        for (int k = 0; k < 64; k++) dram_mem[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_readback();
        t_map();
        t_stored_bits();
        t_field0();
        t_outside();
        t_stray();
        t_next_cycle();
        t_data();
        summary();
        $finish;
    end

endmodule